// File: doc/BRIEF.md
# Configurable Parallel CRC Engine

This block computes a cyclic redundancy check over a stream of data words, one word for every clock in which it is enabled. The CRC standard is selected at run time through five input ports: the generator polynomial, the value that seeds the state register, the mask applied to the final result, a flag that reverses the bit order of each incoming word, and a flag that reverses the bit order of the result. When these ports are tied to constants, synthesis folds the update logic down to the fixed XOR network for that standard.

The word width is a parameter and does not depend on the CRC width. All bits of a word are folded into the state within a single cycle. With a width of one, the engine behaves exactly as a bit-serial CRC. A load input reseeds the state at the start of a message. The finalized checksum is driven continuously, so it can be read in the cycle after the last word is absorbed.

An asynchronous reset clears the state to zero. A parameter sets whether the reset is active high or active low.

Top module: `crc_engine`

## Requirements
- R1: While reset is active, the state is zero, so `checksum` equals the final mask (the reflection of zero is zero). The reset acts without waiting for a clock edge.
- R2: A clock edge with `load` high sets the state to `seed`. From the next cycle on, `checksum` shows that seed finalized.
- R3: When `load` and `enable` are both high in the same cycle, the load wins and the data word is discarded.
- R4: A clock edge with `enable` high and `load` low folds `data` into the state. Bits are taken from the most significant end. For each bit, the bit is XORed with the state's top bit, the state shifts left by one place, and `poly` is XORed in when that XOR was 1. For polynomial 0x1021, seed 0xFFFF, no reflection and mask 0, the ASCII message "123456789" yields 0x29B1.
- R5: When `refl_in` is 1, each word is bit-reversed before it is folded in, so its least significant bit goes first. For polynomial 0x8005, seed 0xFFFF, mask 0xFFFF and both flags set, "123456789" yields 0xB4C8.
- R6: `checksum` is the state, bit-reversed when `refl_out` is 1, and then XORed with `fin_xor`. The reversal happens before the mask is applied.
- R7: The same message fed as 4-bit words gives the same checksum as when fed as 8-bit words. With `refl_in` set, the low nibble of each byte goes first.
- R8: With a word width of 1, feeding a message one bit at a time, from the most significant bit of each byte, gives the same checksum as the byte-wide engine (0x29B1 for the R4 configuration).
- R9: A clock edge with `load` and `enable` both low leaves the state unchanged, whatever `data` holds.
- R10: The parameter `RST_LEVEL` selects the active reset level. Value 1 makes `rst` active high, and value 0 makes it active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active level set by RST_LEVEL |
| poly | input | CRC_W | Generator polynomial without its top term |
| seed | input | CRC_W | Value loaded into the state by `load` |
| fin_xor | input | CRC_W | Mask XORed into the finalized result |
| refl_in | input | 1 | Reverse each data word before absorbing it |
| refl_out | input | 1 | Reverse the state before applying the mask |
| load | input | 1 | Reseed the state on the clock edge |
| enable | input | 1 | Absorb `data` on the clock edge |
| data | input | DATA_W | Data word |
| checksum | output | CRC_W | Finalized checksum of the current state |

## Verification
Reseeding and absorbing a word can both be requested on the same edge. The bench provokes this by raising `load` and `enable` together while `data` carries a nonzero word. It judges the outcome by the checksum in the next cycle, which must equal the finalized seed and carry no trace of the word. The engine is also reset asynchronously in the middle of a stream, and its checksum must show the final mask at once, before any clock edge.

// File: rtl/crc_pkg.sv
package crc_pkg;

    // Operation chosen for the state register on the next edge.
    typedef enum logic [1:0] {
        CRC_OP_HOLD   = 2'd0,
        CRC_OP_LOAD   = 2'd1,
        CRC_OP_ABSORB = 2'd2
    } crc_op_e;

endpackage

// File: rtl/crc_bitrev.sv
module crc_bitrev #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] rev;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_rev
            assign rev[i] = din[W-1-i];
        end
    endgenerate

    assign dout = en ? rev : din;
endmodule

// File: rtl/crc_step.sv
module crc_step #(
    parameter int CRC_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [CRC_W-1:0]  poly,
    input  logic [DATA_W-1:0] word,
    output logic [CRC_W-1:0]  crc_out
);
    localparam int STAGES = DATA_W + 1;

    logic [CRC_W-1:0] chain [STAGES];

    assign chain[0] = crc_in;

    genvar k;
    generate
        for (k = 0; k < DATA_W; k++) begin : g_bit
            logic fb;
            assign fb = word[DATA_W-1-k] ^ chain[k][CRC_W-1];
            assign chain[k+1] = {chain[k][CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
    endgenerate

    assign crc_out = chain[DATA_W];
endmodule

// File: rtl/crc_finalize.sv
module crc_finalize #(
    parameter int CRC_W = 16
) (
    input  logic [CRC_W-1:0] state,
    input  logic             refl_out,
    input  logic [CRC_W-1:0] fin_xor,
    output logic [CRC_W-1:0] result
);
    logic [CRC_W-1:0] ordered;

    crc_bitrev #(.W(CRC_W)) u_rev (
        .en   (refl_out),
        .din  (state),
        .dout (ordered)
    );

    assign result = ordered ^ fin_xor;
endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
    parameter int   CRC_W     = 16,
    parameter int   DATA_W    = 8,
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CRC_W-1:0]  poly,
    input  logic [CRC_W-1:0]  seed,
    input  logic [CRC_W-1:0]  fin_xor,
    input  logic              refl_in,
    input  logic              refl_out,
    input  logic              load,
    input  logic              enable,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  checksum
);
    import crc_pkg::*;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } state_t;

    state_t           st_d, st_q;
    crc_op_e          op;
    logic [DATA_W-1:0] word_ord;
    logic [CRC_W-1:0]  crc_next;

    crc_bitrev #(.W(DATA_W)) u_in_rev (
        .en   (refl_in),
        .din  (data),
        .dout (word_ord)
    );

    crc_step #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_step (
        .crc_in  (st_q.crc),
        .poly    (poly),
        .word    (word_ord),
        .crc_out (crc_next)
    );

    crc_finalize #(.CRC_W(CRC_W)) u_fin (
        .state    (st_q.crc),
        .refl_out (refl_out),
        .fin_xor  (fin_xor),
        .result   (checksum)
    );

    // Load outranks absorb.
    always_comb begin
        if (load)        op = CRC_OP_LOAD;
        else if (enable) op = CRC_OP_ABSORB;
        else             op = CRC_OP_HOLD;
    end

    always_comb begin
        st_d = st_q;
        case (op)
            CRC_OP_LOAD:   st_d.crc = seed;
            CRC_OP_ABSORB: st_d.crc = crc_next;
            default:       st_d     = st_q;
        endcase
    end

    generate
        if (RST_LEVEL) begin : g_rst_hi
            always_ff @(posedge clk or posedge rst) begin
                if (rst) st_q <= '0;
                else     st_q <= st_d;
            end
        end else begin : g_rst_lo
            always_ff @(posedge clk or negedge rst) begin
                if (!rst) st_q <= '0;
                else      st_q <= st_d;
            end
        end
    endgenerate
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
    parameter int   CRC_W     = 16,
    parameter logic RST_LEVEL = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic [CRC_W-1:0] seed,
    input logic [CRC_W-1:0] fin_xor,
    input logic             refl_out,
    input logic             load,
    input logic             enable,
    input logic [CRC_W-1:0] checksum,
    input logic [CRC_W-1:0] crc_q
);
    logic rst_act;
    assign rst_act = (rst == RST_LEVEL);

    // R1: reset seen at an edge leaves a zero state afterwards
    p_reset_clear_r1: assert property (@(posedge clk)
        rst_act |=> (crc_q == '0));

    // R2, R3: load reseeds, regardless of enable
    p_load_seed_r2: assert property (@(posedge clk) disable iff (rst_act)
        load |=> (crc_q == $past(seed)));

    // R9: idle edges keep the state
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst_act)
        (!load && !enable) |=> $stable(crc_q));

    // R6: without reflection the output is state XOR mask
    p_final_mask_r6: assert property (@(posedge clk) disable iff (rst_act)
        !refl_out |-> ((checksum ^ fin_xor) == crc_q));
endmodule

bind crc_engine crc_engine_chk #(.CRC_W(CRC_W), .RST_LEVEL(RST_LEVEL)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .seed     (seed),
    .fin_xor  (fin_xor),
    .refl_out (refl_out),
    .load     (load),
    .enable   (enable),
    .checksum (checksum),
    .crc_q    (st_q.crc)
);

// File: tb/tb_crc_engine.sv
module tb_crc_engine;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // byte engine and nibble engine, active-low reset
    logic        rst_n = 1'b0;
    logic [15:0] c_poly = 16'h8005, c_seed = 16'hFFFF, c_fx = 16'hFFFF;
    logic        c_rin = 1'b1, c_rout = 1'b1;
    logic        b_load = 1'b0, b_en = 1'b0;
    logic [7:0]  b_data = 8'h00;
    logic [15:0] b_sum;
    logic        n_load = 1'b0, n_en = 1'b0;
    logic [3:0]  n_data = 4'h0;
    logic [15:0] n_sum;
    // serial engine, active-high reset
    logic        s_rst = 1'b1;
    logic [15:0] s_fx = 16'h1234;
    logic        s_load = 1'b0, s_en = 1'b0;
    logic [0:0]  s_data = 1'b0;
    logic [15:0] s_sum;

    crc_engine #(.CRC_W(16), .DATA_W(8), .RST_LEVEL(1'b0)) dut (
        .clk(clk), .rst(rst_n), .poly(c_poly), .seed(c_seed), .fin_xor(c_fx),
        .refl_in(c_rin), .refl_out(c_rout), .load(b_load), .enable(b_en),
        .data(b_data), .checksum(b_sum));

    crc_engine #(.CRC_W(16), .DATA_W(4), .RST_LEVEL(1'b0)) dut_nib (
        .clk(clk), .rst(rst_n), .poly(c_poly), .seed(c_seed), .fin_xor(c_fx),
        .refl_in(c_rin), .refl_out(c_rout), .load(n_load), .enable(n_en),
        .data(n_data), .checksum(n_sum));

    crc_engine #(.CRC_W(16), .DATA_W(1), .RST_LEVEL(1'b1)) dut_ser (
        .clk(clk), .rst(s_rst), .poly(16'h1021), .seed(16'hFFFF), .fin_xor(s_fx),
        .refl_in(1'b0), .refl_out(1'b0), .load(s_load), .enable(s_en),
        .data(s_data), .checksum(s_sum));

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t        sb_q[$];
    logic [15:0] m_crc = 16'h0000;

    function automatic logic [15:0] m_step(input logic [15:0] c, input logic [15:0] p,
                                           input bit rin, input logic [7:0] d, input int w);
        logic [15:0] r = c;
        for (int i = w - 1; i >= 0; i--) begin
            bit b;
            b = (rin ? d[w-1-i] : d[i]) ^ r[15];
            r = {r[14:0], 1'b0};
            if (b) r = r ^ p;
        end
        return r;
    endfunction

    function automatic logic [15:0] m_final(input logic [15:0] c, input bit rout,
                                            input logic [15:0] fx);
        logic [15:0] r = c;
        if (rout) for (int i = 0; i < 16; i++) r[i] = c[15-i];
        return r ^ fx;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus to the byte engine and predicts its output
    task automatic drive(input bit ld, input bit en, input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        b_load = ld; b_en = en; b_data = d;
        if (ld)      m_crc = c_seed;
        else if (en) m_crc = m_step(m_crc, c_poly, c_rin, d, 8);
        e.val = m_final(m_crc, c_rout, c_fx);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle_byte();
        @(negedge clk);
        b_load = 1'b0; b_en = 1'b0;
    endtask

    // monitor: compares one predicted value after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, b_sum, e.val);
            end
        end
    end

    string msg = "123456789";

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset byte engine", b_sum, 16'hFFFF);
        check("R10 active-high reset serial", s_sum, 16'h1234);
        rst_n = 1'b1; s_rst = 1'b0;
        @(negedge clk);

        // R5 USB variant, bytes
        drive(1'b1, 1'b0, 8'h00, "R2 seed load");
        for (int i = 0; i < 9; i++) drive(1'b0, 1'b1, msg[i], "R5 reflected absorb");
        idle_byte();
        check("R5 USB check value", b_sum, 16'hB4C8);

        // R9 idle with changing data
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 8'hA5 + 8'(i), "R9 idle hold");
        idle_byte();
        check("R9 held value", b_sum, 16'hB4C8);

        // R3 load and enable together
        drive(1'b0, 1'b1, 8'h3C, "R4 absorb before collision");
        drive(1'b1, 1'b1, 8'h5A, "R3 load beats enable");
        idle_byte();
        check("R3 finalized seed", b_sum, 16'h0000);

        // R4 non-reflected variant
        @(negedge clk);
        c_poly = 16'h1021; c_rin = 1'b0; c_rout = 1'b0; c_fx = 16'h0000;
        drive(1'b1, 1'b0, 8'h00, "R2 reseed");
        for (int i = 0; i < 9; i++) drive(1'b0, 1'b1, msg[i], "R4 msb-first absorb");
        idle_byte();
        check("R4 check value", b_sum, 16'h29B1);

        // R6 reflection before mask
        @(negedge clk);
        c_rout = 1'b1; c_fx = 16'h00FF;
        drive(1'b0, 1'b0, 8'h00, "R6 reflect then mask");
        idle_byte();
        check("R6 reflect then mask", b_sum, m_final(16'h29B1, 1'b1, 16'h00FF));

        // R7 nibble engine, USB variant
        @(negedge clk);
        c_poly = 16'h8005; c_rin = 1'b1; c_rout = 1'b1; c_fx = 16'hFFFF;
        n_load = 1'b1;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); n_load = 1'b0; n_en = 1'b1; n_data = msg[i][3:0];
            @(negedge clk); n_data = msg[i][7:4];
        end
        @(negedge clk); n_en = 1'b0;
        check("R7 nibble equals byte", n_sum, 16'hB4C8);

        // R8 serial engine
        s_fx = 16'h0000;
        @(negedge clk); s_load = 1'b1;
        for (int i = 0; i < 9; i++) begin
            for (int j = 7; j >= 0; j--) begin
                @(negedge clk); s_load = 1'b0; s_en = 1'b1; s_data = msg[i][j];
            end
        end
        @(negedge clk); s_en = 1'b0;
        check("R8 serial check value", s_sum, 16'h29B1);

        // R10/R1 asynchronous mid-stream reset
        s_fx = 16'h0F0F;
        #1 s_rst = 1'b1;
        #1 check("R10 async reset mid-stream", s_sum, 16'h0F0F);
        @(negedge clk); s_rst = 1'b0;

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule